// File: doc/BRIEF.md
# Bus Pin Software Override

This unit sits between a two-wire serial bus controller and the bus's two open-drain pins, the clock line and the data line. In normal operation the controller's pull-low requests pass through to the pads. Software can move both pins at once into software mode. In that mode each pin's pull-low comes from a software output latch and a direction bit. Software can then toggle the clock line to clear a bus that another device is holding in a stuck state.

Software reaches the unit through a simple single-port register interface. A write strobe carries an address and data in the same cycle. A read returns registered data one cycle after the address is presented. The latch is never written directly. A set register raises latch bits and a clear register lowers them, so one pin can change without a read-modify-write of the other pin. Both live pad levels are synchronized and can be read in either mode. The pads are open-drain: the unit only ever asks for a pin to be pulled low, and an external pull-up supplies the high level.

Top module: `bus_pin_override`

## Requirements
- R1: After synchronous reset the unit is in controller mode, both direction bits are 0, both latch bits are 1, and neither pin is pulled low.
- R2: In controller mode, `scl_pull_low` and `sda_pull_low` equal `ctl_scl_low` and `ctl_sda_low` as sampled at the previous clock edge.
- R3: A write to offset 0x48 loads the mode bit from data bit 0, where 1 selects software mode for both pins and 0 selects controller mode. A read of 0x48 returns the mode bit in bit 0 and zeros in all other bits.
- R4: A write to offset 0x4C sets the direction bits: data bit 0 makes the clock pin an output and data bit 1 makes the data pin an output. Reads of 0x4C return these two bits.
- R5: A write to offset 0x58 sets to 1 each latch bit whose data bit is 1 (bit 0 for the clock, bit 1 for the data line). Data bits that are 0 leave the latch unchanged.
- R6: A write to offset 0x5C clears to 0 each latch bit whose data bit is 1 (bit 0 for the clock, bit 1 for the data line). Data bits that are 0 leave the latch unchanged.
- R7: A read of offset 0x54 returns the latch value in bits 1:0. Writes to 0x54 and to 0x50 have no effect.
- R8: In software mode, a pin is pulled low one cycle after its direction bit is 1 and its latch bit is 0. A pin whose direction is input, or whose latch is high, is released.
- R9: In both modes, a read of offset 0x50 returns the clock pad level in bit 0 and the data pad level in bit 1. Each level passes through a two-flop synchronizer first. `ctl_scl_in` and `ctl_sda_in` pass the raw pad levels to the controller.
- R10: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| ctl_scl_low | input | 1 | Controller request to pull the clock line low |
| ctl_sda_low | input | 1 | Controller request to pull the data line low |
| ctl_scl_in | output | 1 | Clock pad level passed to the controller |
| ctl_sda_in | output | 1 | Data pad level passed to the controller |
| scl_pad | input | 1 | Sensed clock pad level |
| sda_pad | input | 1 | Sensed data pad level |
| scl_pull_low | output | 1 | Enable of the clock pad's open-drain pull-down |
| sda_pull_low | output | 1 | Enable of the data pad's open-drain pull-down |

## Verification
A mode switch can arrive in the same cycle in which the controller is requesting a pull-low. The bench holds both controller requests active, writes the mode register to 1 with both latch bits high, and expects both pins to be released on the next cycle. It then writes the mode register back to 0 and expects the controller's request to return, with the latch value kept intact. Pad sensing also overlaps with driving: in every direction, latch and external-holder combination, the bench reads the input register and expects the wired-AND of the unit's own pull-down and the external one.

// File: rtl/bpo_pkg.sv
package bpo_pkg;
  // pin count is fixed by the function: one clock, one data line
  localparam int unsigned NPIN    = 2;
  localparam int unsigned PIN_CLK = 0;
  localparam int unsigned PIN_DAT = 1;

  // register byte offsets
  localparam int unsigned OFS_MODE = 32'h48;
  localparam int unsigned OFS_DIR  = 32'h4C;
  localparam int unsigned OFS_LVL  = 32'h50;
  localparam int unsigned OFS_LAT  = 32'h54;
  localparam int unsigned OFS_SET  = 32'h58;
  localparam int unsigned OFS_CLR  = 32'h5C;
endpackage

// File: rtl/bpo_regs.sv
module bpo_regs
  import bpo_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPIN-1:0]   pin_level,
  output logic              sw_mode,
  output logic [NPIN-1:0]   dir,
  output logic [NPIN-1:0]   latch,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(OFS_LVL);
  localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(OFS_LAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  logic [NPIN-1:0]   wbits;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata_hi;

  assign wbits           = wdata[NPIN-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:NPIN];

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_MODE:  rd_mux[0]        = sw_mode;
      A_DIR:   rd_mux[NPIN-1:0] = dir;
      A_LVL:   rd_mux[NPIN-1:0] = pin_level;
      A_LAT:   rd_mux[NPIN-1:0] = latch;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_mode <= 1'b0;
      dir     <= '0;
      latch   <= '1;
      rdata   <= '0;
    end else begin
      rdata <= rd_mux;
      if (we) begin
        case (addr)
          A_MODE:  sw_mode <= wdata[0];
          A_DIR:   dir     <= wbits;
          A_SET:   latch   <= latch | wbits;
          A_CLR:   latch   <= latch & ~wbits;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bpo_sync.sv
module bpo_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;   // idle bus reads high
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/bpo_pin_drive.sv
module bpo_pin_drive #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_mode,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] latch,
  input  logic [WIDTH-1:0] ctl_low,
  output logic [WIDTH-1:0] pull_low
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)          pull_low[i] <= 1'b0;
      else if (sw_mode) pull_low[i] <= dir[i] & ~latch[i];
      else              pull_low[i] <= ctl_low[i];
    end
  end
endmodule

// File: rtl/bus_pin_override.sv
module bus_pin_override
  import bpo_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ctl_scl_low,
  input  logic              ctl_sda_low,
  output logic              ctl_scl_in,
  output logic              ctl_sda_in,
  input  logic              scl_pad,
  input  logic              sda_pad,
  output logic              scl_pull_low,
  output logic              sda_pull_low
);
  logic              sw_mode;
  logic [NPIN-1:0]   dir_q;
  logic [NPIN-1:0]   latch_q;
  logic [NPIN-1:0]   pad_raw;
  logic [NPIN-1:0]   pad_sync;
  logic [NPIN-1:0]   ctl_low;
  logic [NPIN-1:0]   pull_low;

  assign pad_raw[PIN_CLK] = scl_pad;
  assign pad_raw[PIN_DAT] = sda_pad;
  assign ctl_low[PIN_CLK] = ctl_scl_low;
  assign ctl_low[PIN_DAT] = ctl_sda_low;
  assign ctl_scl_in       = scl_pad;
  assign ctl_sda_in       = sda_pad;
  assign scl_pull_low     = pull_low[PIN_CLK];
  assign sda_pull_low     = pull_low[PIN_DAT];

  bpo_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pin_level(pad_sync), .sw_mode(sw_mode), .dir(dir_q), .latch(latch_q),
    .rdata(reg_rdata)
  );

  bpo_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_raw), .q(pad_sync)
  );

  bpo_pin_drive #(.WIDTH(NPIN)) u_drive (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .dir(dir_q), .latch(latch_q),
    .ctl_low(ctl_low), .pull_low(pull_low)
  );
endmodule

// File: rtl/bpo_checker.sv
module bpo_checker
  import bpo_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        wdata_lo,
  input logic              ctl_scl_low,
  input logic              ctl_sda_low,
  input logic              scl_pull_low,
  input logic              sda_pull_low,
  input logic              sw_mode,
  input logic [1:0]        dir,
  input logic [1:0]        latch
);
  logic hit_mode, hit_set, hit_clr, hit_state;
  assign hit_mode  = reg_addr == ADDR_W'(OFS_MODE);
  assign hit_set   = reg_addr == ADDR_W'(OFS_SET);
  assign hit_clr   = reg_addr == ADDR_W'(OFS_CLR);
  assign hit_state = hit_mode || hit_set || hit_clr || reg_addr == ADDR_W'(OFS_DIR);

  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!scl_pull_low && !sda_pull_low && !sw_mode));

  a_r2_ctl_follow_clk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sw_mode)) |-> scl_pull_low == $past(ctl_scl_low));

  a_r2_ctl_follow_dat: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sw_mode)) |-> sda_pull_low == $past(ctl_sda_low));

  a_r3_mode_write: assert property (@(posedge clk) disable iff (rst)
    (reg_we && hit_mode) |=> sw_mode == $past(wdata_lo[0]));

  a_r5_set_bit: assert property (@(posedge clk) disable iff (rst)
    (reg_we && hit_set && wdata_lo[0]) |=> latch[0]);

  a_r6_clear_bit: assert property (@(posedge clk) disable iff (rst)
    (reg_we && hit_clr && wdata_lo[1]) |=> !latch[1]);

  a_r8_input_released_clk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sw_mode) && !$past(dir[0])) |-> !scl_pull_low);

  a_r8_input_released_dat: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sw_mode) && !$past(dir[1])) |-> !sda_pull_low);

  a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !hit_state) |=> ($stable(dir) && $stable(latch) && $stable(sw_mode)));
endmodule

bind bus_pin_override bpo_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .wdata_lo(reg_wdata[1:0]), .ctl_scl_low(ctl_scl_low), .ctl_sda_low(ctl_sda_low),
  .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
  .sw_mode(sw_mode), .dir(dir_q), .latch(latch_q)
);

// File: tb/bus_pin_override_test.sv
`timescale 1ns/1ps
module bus_pin_override_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] A_MODE = 8'h48, A_DIR = 8'h4C, A_LVL = 8'h50,
                            A_LAT = 8'h54, A_SET = 8'h58, A_CLR = 8'h5C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic ctl_scl_low = 1'b0, ctl_sda_low = 1'b0;
  logic ctl_scl_in, ctl_sda_in;
  logic scl_pull_low, sda_pull_low;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic scl_pad, sda_pad;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  // open-drain wires with pull-up
  assign scl_pad = ~(scl_pull_low | ext_scl_low);
  assign sda_pad = ~(sda_pull_low | ext_sda_low);

  bus_pin_override uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_scl_low(ctl_scl_low), .ctl_sda_low(ctl_sda_low),
    .ctl_scl_in(ctl_scl_in), .ctl_sda_in(ctl_sda_in),
    .scl_pad(scl_pad), .sda_pad(sda_pad),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int pulls();
    return {30'd0, sda_pull_low, scl_pull_low};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pulls", pulls(), 0);
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_DIR, v);  chk("R1 dir", v, 0);
    rd(A_LAT, v);  chk("R1 latch", v, 3);

    // R10 unmapped
    rd(8'h00, v); chk("R10 read unmapped", v, 0);
    wr(8'h40, 16'hFFFF); wr(8'h60, 16'h0003);
    rd(A_DIR, v); chk("R10 dir untouched", v, 0);
    rd(A_LAT, v); chk("R10 latch untouched", v, 3);

    // R2 / R9 controller-mode sweep
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 4; e++) begin
        @(negedge clk);
        ctl_scl_low = c[0]; ctl_sda_low = c[1];
        ext_scl_low = e[0]; ext_sda_low = e[1];
        settle();
        chk("R2 pulls follow controller", pulls(), c);
        chk("R9 raw clk to controller", int'(ctl_scl_in), int'(!(c[0] | e[0])));
        chk("R9 raw dat to controller", int'(ctl_sda_in), int'(!(c[1] | e[1])));
        rd(A_LVL, v); chk("R9 level ctl mode", v, (~(c | e)) & 3);
      end
    end
    @(negedge clk);
    ext_scl_low = 1'b0; ext_sda_low = 1'b0;

    // R3 / R4 readback
    wr(A_MODE, 16'hFFFE); rd(A_MODE, v); chk("R3 mode bit0 only", v, 0);
    wr(A_DIR, 16'hFFFE);  rd(A_DIR, v);  chk("R4 dir readback", v, 2);
    wr(A_DIR, 16'h0001);  rd(A_DIR, v);  chk("R4 dir readback clk", v, 1);

    // R7 writes to latch-read and level registers ignored
    wr(A_LAT, 16'h0000); rd(A_LAT, v); chk("R7 latch write ignored", v, 3);
    wr(A_LVL, 16'h0000); rd(A_LAT, v); chk("R7 level write ignored", v, 3);
    rd(A_DIR, v); chk("R7 dir after ignored writes", v, 1);

    // same-cycle case: mode switch while controller pulls low
    wr(A_DIR, 16'h0003);
    @(negedge clk); ctl_scl_low = 1'b1; ctl_sda_low = 1'b1;
    settle();
    chk("R2 controller pulls before switch", pulls(), 3);
    wr(A_MODE, 16'h0001);
    @(negedge clk);
    chk("R3 switch releases despite controller", pulls(), 0);
    wr(A_MODE, 16'h0000);
    @(negedge clk);
    chk("R3 return to controller", pulls(), 3);
    rd(A_LAT, v); chk("R3 latch kept across switch", v, 3);
    @(negedge clk); ctl_scl_low = 1'b0; ctl_sda_low = 1'b0;

    // R6 single clear, R5 single set
    wr(A_CLR, 16'h0001); rd(A_LAT, v); chk("R6 clear clk bit", v, 2);
    wr(A_SET, 16'h0001); rd(A_LAT, v); chk("R5 set clk bit", v, 3);

    // R8 / R5 / R6 / R9 software-mode sweep
    wr(A_MODE, 16'h0001);
    for (int d = 0; d < 4; d++) begin
      for (int l = 0; l < 4; l++) begin
        for (int e = 0; e < 4; e++) begin
          int expp;
          @(negedge clk);
          ext_scl_low = e[0]; ext_sda_low = e[1];
          wr(A_DIR, 16'(d));
          wr(A_CLR, 16'h0003);
          wr(A_SET, 16'(l));
          wr(A_SET, 16'h0000);   // zero bits: no effect
          wr(A_CLR, 16'h0000);   // zero bits: no effect
          settle();
          expp = d & ~l & 3;
          chk("R8 software pulls", pulls(), expp);
          rd(A_LAT, v); chk("R5 R6 latch after set/clear", v, l);
          rd(A_LVL, v); chk("R9 level sw mode", v, (~(expp | e)) & 3);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule